// File: doc/BRIEF.md
# Per-Channel Audio Delay Line

This block holds back each audio channel by its own whole number of sample periods. Every channel owns a private region of one shared single-port sample memory. On each frame strobe the block stores the new sample of every active channel at the shared write position. It then fetches, for each channel, the sample stored that many frames earlier and presents all channels together on a registered output with a one-cycle valid pulse. Delays are loaded through a small register write port, one channel at a time.

A mode input picks between two active channels and the full channel count. This choice sets how the memory is divided: half of it per channel in two-channel mode, one N-th of it per channel in full mode. Changing a delay, or changing the mode, makes the affected history read as silence until fresh samples fill it, so old audio never reaches the output. All memory work for a frame is time-multiplexed and takes three clocks per active channel plus two. This is far below the 128 system clocks a frame allows.

Top module: `chan_delay_line`

## Requirements
- R1: Each active channel c outputs the sample it received d frames earlier, where d is the value last written to channel c's delay register. It is independent of the other channels' delays.
- R2: A delay of 0 returns the sample presented with the same frame strobe.
- R3: With `mode_8ch`=0, channels 0 and 1 are active and each holds DEPTH/2 samples. With `mode_8ch`=1, all NCH channels are active and each holds DEPTH/NCH samples. The largest usable delay is the region size minus one.
- R4: A delay register value at or above the region size acts as region size minus one.
- R5: A history position not written since the channel was last cleared reads as 0. Writing a channel's delay clears only that channel.
- R6: With `mode_8ch`=0, output lanes 2 to NCH-1 are 0.
- R7: `dout_valid` is high for exactly one cycle, 3*N+1 rising edges after the edge that samples `frame_stb` (N = active channels). `dout` changes only together with that pulse.
- R8: A `frame_stb` that arrives while a frame is being processed is ignored.
- R9: After reset, `dout` is 0, `dout_valid` is 0, all delays are 0 and two-channel mode is assumed.
- R10: `mode_8ch` is sampled at each accepted frame strobe. A value different from the previous one clears the history of all channels and restarts the write position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_8ch | input | 1 | 1 = all NCH channels, 0 = two channels |
| frame_stb | input | 1 | One-cycle strobe: a new frame of samples is on `din` |
| din | input | NCH*DW | Input samples, channel c at bits [c*DW +: DW] |
| cfg_we | input | 1 | Delay register write enable |
| cfg_ch | input | log2(NCH) | Channel whose delay is written |
| cfg_delay | input | AW | Delay in frames |
| dout | output | NCH*DW | Delayed samples, same lane layout as `din` |
| dout_valid | output | 1 | One-cycle pulse when `dout` is updated |

## Verification
Random samples pass through zero delay, small unequal delays and the largest delay of each mode. This separates a correct address subtraction from an off-by-one or a lane mix-up between channels. Over-range delay values tell clamping apart from wrap-around. The start of each run, a single-channel delay change and a mode switch show whether unwritten history is masked to silence, and whether that masking is limited to the channel that was reconfigured. A strobe injected mid-frame and the two-channel mode's idle lanes check that nothing leaks into the output.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WR,
    S_RD,
    S_LAT,
    S_DONE
  } seq_st_e;
endpackage

// File: rtl/cdl_ram.sv
module cdl_ram #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/cdl_bank.sv
module cdl_bank #(
  parameter int NCH = 8,
  parameter int AW  = 10,
  localparam int CHW = $clog2(NCH),
  localparam int OW  = AW - 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OW-1:0]  mask,
  input  logic           clr_all,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [AW-1:0]  cfg_delay,
  input  logic [CHW-1:0] sel_ch,
  input  logic           adv,
  output logic [OW-1:0]  eff_dly,
  output logic           hist_ok
);
  logic [AW-1:0] dly_r  [NCH];
  logic [OW-1:0] fill_r [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        dly_r[g]  <= '0;
        fill_r[g] <= '0;
      end else begin
        if (cfg_we && cfg_ch == CHW'(g)) dly_r[g] <= cfg_delay;
        if ((cfg_we && cfg_ch == CHW'(g)) || clr_all)
          fill_r[g] <= '0;
        else if (adv && sel_ch == CHW'(g) && fill_r[g] < mask)
          fill_r[g] <= fill_r[g] + 1'b1;
      end
    end

    // R5: count of valid history never passes the region bound
    p_fill_bound_r5: assert property (@(posedge clk) disable iff (rst)
      fill_r[g] <= mask);
  end

  logic [AW-1:0] raw_sel;
  assign raw_sel = dly_r[sel_ch];

  always_comb begin
    eff_dly = (raw_sel > {1'b0, mask}) ? mask : raw_sel[OW-1:0];
    hist_ok = (eff_dly <= fill_r[sel_ch]);
  end
endmodule

// File: rtl/cdl_seq.sv
module cdl_seq
  import cdl_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 10,
  localparam int CHW = $clog2(NCH),
  localparam int OW  = AW - 1,
  localparam int RLO = AW - CHW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           frame_stb,
  input  logic           mode_in,
  input  logic [OW-1:0]  mask,
  input  logic [OW-1:0]  eff_dly,
  output logic           mode_q,
  output logic           start,
  output logic           clr_all,
  output logic [CHW-1:0] ch,
  output logic           ram_we,
  output logic [AW-1:0]  ram_addr,
  output logic           lat,
  output logic           done
);
  seq_st_e        st;
  logic [OW-1:0]  wp;
  logic [OW-1:0]  off;
  logic [CHW-1:0] last_ch;

  assign start   = (st == S_IDLE) && frame_stb;
  assign clr_all = start && (mode_in != mode_q);
  assign last_ch = mode_q ? CHW'(NCH - 1) : CHW'(1);
  assign ram_we  = (st == S_WR);
  assign lat     = (st == S_LAT);
  assign done    = (st == S_DONE);

  always_comb begin
    off = (st == S_WR) ? wp : ((wp - eff_dly) & mask);
    if (mode_q) ram_addr = {ch, off[RLO-1:0]};
    else        ram_addr = {ch[0], off};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      wp     <= '0;
      ch     <= '0;
      mode_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          st     <= S_WR;
          ch     <= '0;
          mode_q <= mode_in;
          if (clr_all) wp <= '0;
        end
        S_WR:  st <= S_RD;
        S_RD:  st <= S_LAT;
        S_LAT: begin
          if (ch == last_ch) st <= S_DONE;
          else begin
            st <= S_WR;
            ch <= ch + 1'b1;
          end
        end
        S_DONE: begin
          st <= S_IDLE;
          wp <= (wp + 1'b1) & mask;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8: a strobe during processing never restarts the channel walk
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE && st != S_DONE && frame_stb) |=> !(st == S_WR && ch == '0));
  // R3: write position stays inside the active region
  p_wp_range_r3: assert property (@(posedge clk) disable iff (rst)
    (wp & ~mask) == '0);
  // R10: a mode change restarts the write position and begins the frame
  p_mode_restart_r10: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (wp == '0 && st == S_WR && ch == '0));
endmodule

// File: rtl/chan_delay_line.sv
module chan_delay_line #(
  parameter int NCH = 8,
  parameter int DW  = 16,
  parameter int AW  = 10,
  localparam int CHW = $clog2(NCH),
  localparam int OW  = AW - 1,
  localparam int RLO = AW - CHW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_8ch,
  input  logic              frame_stb,
  input  logic [NCH*DW-1:0] din,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [AW-1:0]     cfg_delay,
  output logic [NCH*DW-1:0] dout,
  output logic              dout_valid
);
  localparam logic [OW-1:0] MASK_ALL = OW'((1 << RLO) - 1);
  localparam logic [OW-1:0] MASK_TWO = '1;

  logic           mode_q, start, clr_all, ram_we, lat, done, hist_ok;
  logic [CHW-1:0] ch;
  logic [AW-1:0]  ram_addr;
  logic [OW-1:0]  mask, eff_dly;
  logic [DW-1:0]  rdata;
  logic [DW-1:0]  cap_r   [NCH];
  logic [DW-1:0]  stage_r [NCH];

  assign mask = mode_q ? MASK_ALL : MASK_TWO;

  cdl_seq #(.NCH(NCH), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .mode_in(mode_8ch),
    .mask(mask), .eff_dly(eff_dly), .mode_q(mode_q), .start(start),
    .clr_all(clr_all), .ch(ch), .ram_we(ram_we), .ram_addr(ram_addr),
    .lat(lat), .done(done)
  );

  cdl_bank #(.NCH(NCH), .AW(AW)) u_bank (
    .clk(clk), .rst(rst), .mask(mask), .clr_all(clr_all),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_delay(cfg_delay),
    .sel_ch(ch), .adv(lat), .eff_dly(eff_dly), .hist_ok(hist_ok)
  );

  cdl_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(cap_r[ch]), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_valid <= 1'b0;
      dout       <= '0;
      for (int c = 0; c < NCH; c++) begin
        cap_r[c]   <= '0;
        stage_r[c] <= '0;
      end
    end else begin
      dout_valid <= done;
      if (start) begin
        for (int c = 0; c < NCH; c++) begin
          cap_r[c]   <= din[c*DW +: DW];
          stage_r[c] <= '0;
        end
      end else if (lat) begin
        stage_r[ch] <= hist_ok ? rdata : '0;
      end
      if (done)
        for (int c = 0; c < NCH; c++) dout[c*DW +: DW] <= stage_r[c];
    end
  end

  // R7: valid is a single-cycle pulse
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    dout_valid |=> !dout_valid);
  // R7: output only moves together with the valid pulse
  p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !dout_valid |-> $stable(dout));
  // R6: unused lanes are silent in two-channel mode
  p_idle_lanes_r6: assert property (@(posedge clk) disable iff (rst)
    (dout_valid && !mode_q) |-> (dout[NCH*DW-1:2*DW] == '0));
endmodule

// File: tb/chan_delay_line_tb.sv
module chan_delay_line_tb;
  localparam int CLK_NS = 10;
  localparam int NCH = 8;
  localparam int DW  = 16;
  localparam int AW  = 10;
  localparam int HD  = 512;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mode_8ch = 1'b0;
  logic              frame_stb = 1'b0;
  logic [NCH*DW-1:0] din = '0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_ch = '0;
  logic [AW-1:0]     cfg_delay = '0;
  logic [NCH*DW-1:0] dout;
  logic              dout_valid;

  int nchk = 0, nfail = 0;
  logic [DW-1:0] hist [NCH][HD];
  int fillm [NCH];
  int dlym  [NCH];
  int n = 0;
  bit m8m = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  chan_delay_line #(.NCH(NCH), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .mode_8ch(mode_8ch), .frame_stb(frame_stb),
    .din(din), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_delay(cfg_delay),
    .dout(dout), .dout_valid(dout_valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic set_dly(input int c, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 3'(c); cfg_delay = AW'(v);
    dlym[c] = v; fillm[c] = 0;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // expected value = sample of frame n-d once d frames of history exist, else 0
  task automatic run_frame(input bit m8, input string tag, input bit poke);
    logic [DW-1:0] ex [NCH];
    int nact, mask, d, k, extra;
    nact = m8 ? 8 : 2;
    mask = m8 ? 127 : 511;
    if (m8 != m8m) begin
      for (int c = 0; c < NCH; c++) fillm[c] = 0;
      m8m = m8;
    end
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      din[c*DW +: DW] = DW'($urandom);
      ex[c] = '0;
      if (c < nact) begin
        hist[c][n & (HD-1)] = din[c*DW +: DW];
        d = (dlym[c] > mask) ? mask : dlym[c];
        if (d <= fillm[c]) ex[c] = hist[c][(n - d) & (HD-1)];
        if (fillm[c] < mask) fillm[c]++;
      end
    end
    n++;
    mode_8ch = m8; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    k = 0;
    while (!dout_valid && k < 200) begin
      @(negedge clk);
      k++;
      if (poke && k == 3) begin
        din = {NCH{16'hDEAD}};
        frame_stb = 1'b1;
      end else frame_stb = 1'b0;
    end
    chk(k == 3*nact + 1, "R7 latency", k, 3*nact + 1);
    for (int c = 0; c < NCH; c++)
      chk(dout[c*DW +: DW] == ex[c], (c >= nact) ? "R6 idle lane" : tag,
          dout[c*DW +: DW], ex[c]);
    @(negedge clk);
    chk(!dout_valid, "R7 pulse width", dout_valid, 0);
    if (poke) begin
      extra = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (dout_valid) extra++;
      end
      chk(extra == 0, "R8 busy strobe", extra, 0);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int c = 0; c < NCH; c++) begin fillm[c] = 0; dlym[c] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dout == '0, "R9 reset dout", dout[31:0], 0);
    chk(!dout_valid, "R9 reset valid", dout_valid, 0);

    for (int i = 0; i < 3; i++) run_frame(1'b0, "R2 zero delay", 1'b0);

    set_dly(0, 5); set_dly(1, 1);
    for (int i = 0; i < 30; i++) run_frame(1'b0, "R1 R5 small delays", 1'b0);

    set_dly(0, 511); set_dly(1, 700);
    for (int i = 0; i < 530; i++) run_frame(1'b0, "R3 R4 two-ch max", 1'b0);

    set_dly(0, 0);   set_dly(1, 127); set_dly(2, 300); set_dly(3, 3);
    set_dly(4, 17);  set_dly(5, 64);  set_dly(6, 1);   set_dly(7, 100);
    for (int i = 0; i < 140; i++) run_frame(1'b1, "R10 R3 R4 full mode", 1'b0);

    set_dly(3, 9);
    for (int i = 0; i < 20; i++) run_frame(1'b1, "R5 single clear", 1'b0);

    run_frame(1'b1, "R8 busy frame", 1'b1);
    for (int i = 0; i < 5; i++) run_frame(1'b1, "R8 after busy", 1'b0);

    for (int c = 0; c < NCH; c++) set_dly(c, int'($urandom % 200));
    for (int i = 0; i < 80; i++) run_frame(1'b1, "R1 random delays", 1'b0);

    set_dly(0, 0); set_dly(1, 4);
    for (int i = 0; i < 10; i++) run_frame(1'b0, "R10 R6 back to two", 1'b0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule